// File: doc/BRIEF.md
# Burst-capture storage sensor sequencer

This block times a pixel sensor in which every pixel keeps a short chain of charge storage slots. A train-start trigger opens a capture burst: the block issues a fixed number of evenly spaced transfer strobes. Each one moves the charge collected under the photogate into the pixel's storage chain and shifts the chain of every row at once. The number of strobes equals the storage depth, a parameter: 20 in the full design and 5 in the small array configuration used here. During the burst, no row is selected and nothing is sampled.

When the burst ends, the block reads the whole array in the quiet gap that follows the train, one row at a time. For the selected row, all column converters work in parallel. The block selects the row, pulses the global reset gate, and takes a reset-level sample. For each stored slot it then shifts that row's storage chain and takes a signal-level sample. Finally it releases the row. Every readout step lasts a programmable number of clocks, and so does every capture interval. A single end-of-frame pulse closes the frame. A trigger that arrives while a frame is still running is ignored and reported on a flag.

Top module: `burst_store_seq`

## Requirements
- R1: While reset is held, busy, overrun, frameDone, xferStb, resetGate, sampleValid and every bit of shiftStb and rowSel are low.
- R2: When the block is idle, trainStart sampled high at a clock edge starts a frame. busy is high from the cycle after that edge through the frameDone cycle, and low afterwards.
- R3: A frame issues exactly DEPTH one-cycle xferStb pulses. The first is high in the capDiv-th cycle after the accepting edge, and each later pulse follows capDiv cycles after the one before.
- R4: Every xferStb pulse has all ROWS bits of shiftStb high in the same cycle. From the accepting edge up to the end of the last transfer pulse, rowSel, resetGate and sampleValid stay low, and shiftStb is never high without xferStb.
- R5: Readout is a chain of steps, each lasting rdDiv cycles, with the first step ending rdDiv cycles after the last transfer pulse. For each row the steps are, in order: select, reset (resetGate pulses at its end), reset sample, then one shift step (shiftStb pulses for that row only) and one signal-sample step per slot, then release. That gives 2*DEPTH+4 steps per row.
- R6: A sample is a one-cycle sampleValid pulse at the end of a sample step. sampleIsSig is 0 for the reset-level sample and 1 for a signal-level sample. sampleRow gives the row, with rows read in ascending order from 0. sampleSlot gives the slot, from 0 to DEPTH-1 in ascending order, on signal samples.
- R7: rowSel has at most one bit high. During each row's steps from select through the last signal sample, the bit of the row being read is high. It is low during the release step. sampleValid is only ever high while rowSel[sampleRow] is high.
- R8: frameDone pulses exactly once per frame, at the end of the last row's release step: capDiv*DEPTH - 1 + ROWS*(2*DEPTH+4)*rdDiv cycles after the first cycle following the accepting edge.
- R9: trainStart sampled high while busy is high raises overrun for the one following cycle. It does not change the timing or count of any strobe in the running frame.
- R10: A capDiv or rdDiv value of 0 behaves as a value of 1.
- R11: Once a frame has finished, a new trigger starts a full new frame with the same timing rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| trainStart | input | 1 | Train-start trigger, sampled at each clock edge |
| capDiv | input | DIV_W | Clocks per capture interval |
| rdDiv | input | DIV_W | Clocks per readout step |
| xferStb | output | 1 | Global photogate-to-storage transfer strobe |
| shiftStb | output | ROWS | Per-row storage-chain shift strobes |
| rowSel | output | ROWS | Per-row select, one-hot or zero |
| resetGate | output | 1 | Global reset gate pulse |
| sampleValid | output | 1 | Column converters take a sample this cycle |
| sampleIsSig | output | 1 | 0 = reset-level sample, 1 = signal-level sample |
| sampleRow | output | ROW_W | Row of the current sample |
| sampleSlot | output | SLOT_W | Storage slot of the current signal sample |
| frameDone | output | 1 | End-of-frame pulse |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | An ignored trigger was seen while busy |

## Verification
A slot or row counter that is off by one shows at the ports as a wrong sampleSlot or sampleRow tag on the very next sample. It also shows as a shift strobe on the wrong row within one readout step. A fault in the shared interval timer shifts the cycle of the first transfer strobe, or of the first readout step, by at least one clock. Every strobe and sample after it then drifts by the same amount. The bench therefore compares each event against its exact expected cycle rather than only counting events. A state machine that leaves the capture burst early, or accepts a trigger while busy, shows at once as a sample during the burst or a restarted strobe train. In either case the end-of-frame pulse lands away from its computed cycle.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAPTURE,
    ST_READOUT
  } seqState_t;

  typedef enum logic [2:0] {
    PH_SELECT,
    PH_RESET,
    PH_REFSAMP,
    PH_SHIFT,
    PH_SIGSAMP,
    PH_RELEASE
  } rdPhase_t;

  typedef struct packed {
    logic loadCap;
    logic loadRd;
    logic slotClr;
    logic slotInc;
    logic rowClr;
    logic rowInc;
    logic xferPulse;
    logic resetPulse;
    logic shiftPulse;
    logic samplePulse;
    logic sampleSig;
    logic rowSelEn;
    logic framePulse;
    logic busy;
  } seqStrobes_t;

endpackage

// File: rtl/bss_ctrl.sv
module bss_ctrl
  import bss_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trainStart,
  input  logic        tick,
  input  logic        slotLast,
  input  logic        rowLast,
  output seqStrobes_t stb,
  output logic        overrun
);

  seqState_t state, stateNext;
  rdPhase_t  phase, phaseNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= PH_SELECT;
      overrun <= 1'b0;
    end else begin
      state   <= stateNext;
      phase   <= phaseNext;
      overrun <= trainStart && (state != ST_IDLE);
    end
  end

  always_comb begin
    stb          = '0;
    stateNext    = state;
    phaseNext    = phase;
    stb.busy     = (state != ST_IDLE);
    stb.rowSelEn = (state == ST_READOUT) && (phase != PH_RELEASE);
    case (state)
      ST_IDLE: begin
        if (trainStart) begin
          stateNext   = ST_CAPTURE;
          stb.loadCap = 1'b1;
          stb.slotClr = 1'b1;
        end
      end
      ST_CAPTURE: begin
        if (tick) begin
          stb.xferPulse = 1'b1;
          if (slotLast) begin
            stateNext   = ST_READOUT;
            phaseNext   = PH_SELECT;
            stb.loadRd  = 1'b1;
            stb.slotClr = 1'b1;
            stb.rowClr  = 1'b1;
          end else begin
            stb.slotInc = 1'b1;
            stb.loadCap = 1'b1;
          end
        end
      end
      ST_READOUT: begin
        if (tick) begin
          stb.loadRd = 1'b1;
          case (phase)
            PH_SELECT: phaseNext = PH_RESET;
            PH_RESET: begin
              stb.resetPulse = 1'b1;
              phaseNext      = PH_REFSAMP;
            end
            PH_REFSAMP: begin
              stb.samplePulse = 1'b1;
              phaseNext       = PH_SHIFT;
            end
            PH_SHIFT: begin
              stb.shiftPulse = 1'b1;
              phaseNext      = PH_SIGSAMP;
            end
            PH_SIGSAMP: begin
              stb.samplePulse = 1'b1;
              stb.sampleSig   = 1'b1;
              if (slotLast) begin
                phaseNext = PH_RELEASE;
              end else begin
                stb.slotInc = 1'b1;
                phaseNext   = PH_SHIFT;
              end
            end
            PH_RELEASE: begin
              if (rowLast) begin
                stb.framePulse = 1'b1;
                stateNext      = ST_IDLE;
              end else begin
                stb.rowInc  = 1'b1;
                stb.slotClr = 1'b1;
              end
              phaseNext = PH_SELECT;
            end
            default: phaseNext = PH_SELECT;
          endcase
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/bss_datapath.sv
module bss_datapath
  import bss_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int DEPTH  = 5,
  parameter int DIV_W  = 16,
  localparam int ROW_W  = (ROWS  > 1) ? $clog2(ROWS)  : 1,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       stb,
  input  logic [DIV_W-1:0]  capDiv,
  input  logic [DIV_W-1:0]  rdDiv,
  output logic              tick,
  output logic              slotLast,
  output logic              rowLast,
  output logic              xferStb,
  output logic [ROWS-1:0]   shiftStb,
  output logic [ROWS-1:0]   rowSel,
  output logic              resetGate,
  output logic              sampleValid,
  output logic              sampleIsSig,
  output logic [ROW_W-1:0]  sampleRow,
  output logic [SLOT_W-1:0] sampleSlot,
  output logic              frameDone,
  output logic              busy
);

  logic [DIV_W-1:0]  timerCnt;
  logic [DIV_W-1:0]  capReload, rdReload;
  logic [SLOT_W-1:0] slotCnt;
  logic [ROW_W-1:0]  rowCnt;

  assign capReload = (capDiv == '0) ? '0 : capDiv - DIV_W'(1);
  assign rdReload  = (rdDiv  == '0) ? '0 : rdDiv  - DIV_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (stb.loadCap) begin
      timerCnt <= capReload;
    end else if (stb.loadRd) begin
      timerCnt <= rdReload;
    end else if (timerCnt != '0) begin
      timerCnt <= timerCnt - DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
      rowCnt  <= '0;
    end else begin
      if (stb.slotClr)      slotCnt <= '0;
      else if (stb.slotInc) slotCnt <= slotCnt + SLOT_W'(1);
      if (stb.rowClr)       rowCnt  <= '0;
      else if (stb.rowInc)  rowCnt  <= rowCnt + ROW_W'(1);
    end
  end

  assign tick     = (timerCnt == '0);
  assign slotLast = (slotCnt == SLOT_W'(DEPTH - 1));
  assign rowLast  = (rowCnt  == ROW_W'(ROWS - 1));

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic isCur;
    assign isCur       = (rowCnt == ROW_W'(r));
    assign rowSel[r]   = stb.rowSelEn && isCur;
    assign shiftStb[r] = stb.xferPulse || (stb.shiftPulse && isCur);
  end

  assign xferStb     = stb.xferPulse;
  assign resetGate   = stb.resetPulse;
  assign sampleValid = stb.samplePulse;
  assign sampleIsSig = stb.sampleSig;
  assign sampleRow   = rowCnt;
  assign sampleSlot  = slotCnt;
  assign frameDone   = stb.framePulse;
  assign busy        = stb.busy;

endmodule

// File: rtl/burst_store_seq.sv
module burst_store_seq
  import bss_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int DEPTH  = 5,
  parameter int DIV_W  = 16,
  localparam int ROW_W  = (ROWS  > 1) ? $clog2(ROWS)  : 1,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              trainStart,
  input  logic [DIV_W-1:0]  capDiv,
  input  logic [DIV_W-1:0]  rdDiv,
  output logic              xferStb,
  output logic [ROWS-1:0]   shiftStb,
  output logic [ROWS-1:0]   rowSel,
  output logic              resetGate,
  output logic              sampleValid,
  output logic              sampleIsSig,
  output logic [ROW_W-1:0]  sampleRow,
  output logic [SLOT_W-1:0] sampleSlot,
  output logic              frameDone,
  output logic              busy,
  output logic              overrun
);

  seqStrobes_t stb;
  logic        tick, slotLast, rowLast;

  bss_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .trainStart (trainStart),
    .tick       (tick),
    .slotLast   (slotLast),
    .rowLast    (rowLast),
    .stb        (stb),
    .overrun    (overrun)
  );

  bss_datapath #(.ROWS(ROWS), .DEPTH(DEPTH), .DIV_W(DIV_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .capDiv      (capDiv),
    .rdDiv       (rdDiv),
    .tick        (tick),
    .slotLast    (slotLast),
    .rowLast     (rowLast),
    .xferStb     (xferStb),
    .shiftStb    (shiftStb),
    .rowSel      (rowSel),
    .resetGate   (resetGate),
    .sampleValid (sampleValid),
    .sampleIsSig (sampleIsSig),
    .sampleRow   (sampleRow),
    .sampleSlot  (sampleSlot),
    .frameDone   (frameDone),
    .busy        (busy)
  );

endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
  parameter int ROWS   = 16,
  parameter int ROW_W  = 4,
  parameter int SLOT_W = 3
)(
  input logic              clk,
  input logic              rstN,
  input logic              trainStart,
  input logic              xferStb,
  input logic [ROWS-1:0]   shiftStb,
  input logic [ROWS-1:0]   rowSel,
  input logic              resetGate,
  input logic              sampleValid,
  input logic [ROW_W-1:0]  sampleRow,
  input logic              frameDone,
  input logic              busy,
  input logic              overrun
);

  AST_ROWSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowSel)); // R7

  AST_SAMPLE_ROW_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> rowSel[sampleRow]); // R7

  AST_NO_READ_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    xferStb |-> (!sampleValid && !resetGate && rowSel == '0)); // R4

  AST_XFER_SHIFTS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    xferStb |-> (&shiftStb)); // R4

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    resetGate |-> (!sampleValid && shiftStb == '0)); // R5

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && trainStart) |=> busy); // R2

  AST_FRAME_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !busy); // R8

  AST_OVERRUN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && trainStart) |=> overrun); // R9

  AST_NO_OVERRUN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !trainStart) |=> !overrun); // R9

endmodule

bind burst_store_seq bss_checker #(.ROWS(ROWS), .ROW_W(ROW_W), .SLOT_W(SLOT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .trainStart  (trainStart),
  .xferStb     (xferStb),
  .shiftStb    (shiftStb),
  .rowSel      (rowSel),
  .resetGate   (resetGate),
  .sampleValid (sampleValid),
  .sampleRow   (sampleRow),
  .frameDone   (frameDone),
  .busy        (busy),
  .overrun     (overrun)
);

// File: tb/burst_store_seq_bench.sv
module burst_store_seq_bench;

  localparam int ROWS  = 16;
  localparam int D     = 5;
  localparam int DIV_W = 16;
  localparam int ROW_W = 4;
  localparam int SLOT_W = 3;
  localparam int STEPS_PER_ROW = 2 * D + 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              trainStart = 1'b0;
  logic [DIV_W-1:0]  capDiv = '0;
  logic [DIV_W-1:0]  rdDiv = '0;
  logic              xferStb, resetGate, sampleValid, sampleIsSig, frameDone, busy, overrun;
  logic [ROWS-1:0]   shiftStb, rowSel;
  logic [ROW_W-1:0]  sampleRow;
  logic [SLOT_W-1:0] sampleSlot;

  always #2.5 clk = ~clk;

  burst_store_seq #(.ROWS(ROWS), .DEPTH(D), .DIV_W(DIV_W)) u_burst_store_seq (
    .clk(clk), .rstN(rstN), .trainStart(trainStart), .capDiv(capDiv), .rdDiv(rdDiv),
    .xferStb(xferStb), .shiftStb(shiftStb), .rowSel(rowSel), .resetGate(resetGate),
    .sampleValid(sampleValid), .sampleIsSig(sampleIsSig), .sampleRow(sampleRow),
    .sampleSlot(sampleSlot), .frameDone(frameDone), .busy(busy), .overrun(overrun)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor state
  bit armed = 1'b0;
  int tBase, cEff, rEff, endCyc, ovAt;
  int xCnt, xBad, capBad, rgCnt, rgBad, shCnt, shBad, sCnt, sBad, selBad;
  int fdCnt, fdBad, busyBad, ovSeen, ovBad;

  function automatic int stepEnd(input int step);
    return tBase + cEff * D - 1 + (step + 1) * rEff;
  endfunction

  always @(negedge clk) begin
    if (armed) begin
      if (busy !== ((cyc >= tBase && cyc <= endCyc) ? 1'b1 : 1'b0)) busyBad++;
      if (!$onehot0(rowSel)) selBad++;
      if (cyc < tBase + cEff * D) begin
        if (rowSel != '0 || sampleValid || resetGate) capBad++;
        if (shiftStb != '0 && !xferStb) capBad++;
      end
      if (xferStb) begin
        if (cyc != tBase + cEff - 1 + xCnt * cEff) xBad++;
        if (shiftStb != {ROWS{1'b1}}) capBad++;
        xCnt++;
      end
      if (resetGate) begin
        if (cyc != stepEnd(rgCnt * STEPS_PER_ROW + 1)) rgBad++;
        rgCnt++;
      end
      if (shiftStb != '0 && !xferStb) begin
        int row, s;
        logic [ROWS-1:0] hot;
        row = shCnt / D;
        s   = shCnt % D;
        hot = ROWS'(1) << row;
        if (cyc != stepEnd(row * STEPS_PER_ROW + 3 + 2 * s) || shiftStb != hot) shBad++;
        shCnt++;
      end
      if (sampleValid) begin
        int row, k, st;
        row = sCnt / (D + 1);
        k   = sCnt % (D + 1);
        st  = row * STEPS_PER_ROW + ((k == 0) ? 2 : (4 + 2 * (k - 1)));
        if (cyc != stepEnd(st)) sBad++;
        if (int'(sampleRow) != row) sBad++;
        if (sampleIsSig !== (k != 0)) sBad++;
        if (k != 0 && int'(sampleSlot) != k - 1) sBad++;
        if (rowSel != (ROWS'(1) << row)) selBad++;
        sCnt++;
      end
      if (rowSel != '0 && !sampleValid) begin
        int st;
        st = (cyc - (tBase + cEff * D)) / rEff;
        if (st % STEPS_PER_ROW == STEPS_PER_ROW - 1 && cyc < endCyc) begin
          if (cyc != stepEnd(st)) selBad++;
        end
      end
      if (frameDone) begin
        if (cyc != endCyc) fdBad++;
        fdCnt++;
      end
      if (overrun) begin
        if (cyc != ovAt) ovBad++;
        ovSeen++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && overrun == 1'b0 && frameDone == 1'b0, "R1 status", int'(busy), 0);
    check(xferStb == 1'b0 && resetGate == 1'b0 && sampleValid == 1'b0, "R1 strobes", int'(xferStb), 0);
    check(shiftStb == '0 && rowSel == '0, "R1 rows", int'(rowSel), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // one full frame; ovOffset > 0 injects a second trigger at tBase + ovOffset
  task automatic run_frame(input int cfgCap, input int cfgRd, input int ovOffset, input string tag);
    capDiv = DIV_W'(cfgCap);
    rdDiv  = DIV_W'(cfgRd);
    @(negedge clk);
    cEff   = (cfgCap == 0) ? 1 : cfgCap;
    rEff   = (cfgRd  == 0) ? 1 : cfgRd;
    tBase  = cyc + 1;
    endCyc = tBase + cEff * D - 1 + ROWS * STEPS_PER_ROW * rEff;
    ovAt   = (ovOffset > 0) ? tBase + ovOffset : -1;
    xCnt = 0; xBad = 0; capBad = 0; rgCnt = 0; rgBad = 0; shCnt = 0; shBad = 0;
    sCnt = 0; sBad = 0; selBad = 0; fdCnt = 0; fdBad = 0; busyBad = 0; ovSeen = 0; ovBad = 0;
    armed = 1'b1;
    trainStart = 1'b1;
    @(negedge clk);
    trainStart = 1'b0;
    if (ovOffset > 0) begin
      while (cyc != ovAt - 1) @(negedge clk);
      trainStart = 1'b1;
      @(negedge clk);
      trainStart = 1'b0;
    end
    while (cyc <= endCyc + 3) @(negedge clk);
    armed = 1'b0;
    $display("frame %s done", tag);
    check(busyBad == 0, "R2 busy window", busyBad, 0);
    check(xCnt == D && xBad == 0, "R3 transfer count/spacing", xCnt * 100 + xBad, D * 100);
    check(capBad == 0, "R4 capture quiet + all-row shift", capBad, 0);
    check(rgCnt == ROWS && rgBad == 0, "R5 reset gate steps", rgCnt * 100 + rgBad, ROWS * 100);
    check(shCnt == ROWS * D && shBad == 0, "R5 readout shifts", shCnt * 100 + shBad, ROWS * D * 100);
    check(sCnt == ROWS * (D + 1) && sBad == 0, "R6 sample order/tags", sCnt * 100 + sBad, ROWS * (D + 1) * 100);
    check(selBad == 0, "R7 row select", selBad, 0);
    check(fdCnt == 1 && fdBad == 0, "R8 end of frame", fdCnt * 100 + fdBad, 100);
    if (ovOffset > 0)
      check(ovSeen == 1 && ovBad == 0, "R9 overrun flag", ovSeen * 100 + ovBad, 100);
    else
      check(ovSeen == 0, "R9 no spurious overrun", ovSeen, 0);
  endtask

  initial begin
    test_reset();
    // R9: retrigger during readout
    run_frame(3, 2, 3 * D + 20, "A");
    // R10: zero dividers act as one; R9: retrigger during capture
    run_frame(0, 0, 2, "B");
    // R11: restart with new timing
    run_frame(7, 3, 0, "C");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule